// File: doc/BRIEF.md
# Serial Diagnostic Shadow Register

This block pairs an eight-bit parallel pipeline register with an eight-bit shadow register that can be reached serially, so that a scan string can watch and control the pipeline from a board tester. While the diagnostic mode input is low, the pipeline register loads its parallel data input on every rising clock edge and the shadow register keeps its contents. While the mode input is high, a secondary select picks the diagnostic operation. With the select high, the shadow register shifts serially. With the select low, the serial data input stops carrying data and instead picks the direction of a parallel copy: either from the shadow register into the pipeline register, or from the output pins into the shadow register.

The output pins show the pipeline register while outputs are enabled. While they are disabled, the pins show an externally applied value, and that value is what a pin capture takes in. During a parallel transfer with outputs disabled, the serial output repeats the serial input. The direction choice therefore travels down a string of blocks whose serial outputs feed the next serial inputs. At any other time the serial output presents the most-significant shadow bit.

Top module: `diag_shadow_reg`

## Requirements
- R1: A synchronous active-high reset clears both the shadow register and the pipeline register to 8'h00.
- R2: With `diag_mode_i` low, each rising edge loads `pipe_d_i` into the pipeline register, and the shadow register keeps its value.
- R3: With `diag_mode_i` high and `sec_sel_i` high, each rising edge moves every shadow bit one place toward bit 7 and places `sdin_i` in bit 0.
- R4: Except in the echo condition of R7, `sdout_o` equals bit 7 of the shadow register.
- R5: With `diag_mode_i` high, `sec_sel_i` low and `sdin_i` low, a rising edge copies the shadow register into the pipeline register.
- R6: With `diag_mode_i` high, `sec_sel_i` low and `sdin_i` high, a rising edge copies `pins_o` into the shadow register. `pins_o` equals the pipeline register when `out_en_i` is high and `pin_ext_i` when it is low.
- R7: When `diag_mode_i` is high, `sec_sel_i` is low and `out_en_i` is low, `sdout_o` equals `sdin_i`.
- R8: In diagnostic mode, the pipeline register keeps its value on every edge other than the R5 transfer.
- R9: Two blocks chained serial output to serial input shift a 16-bit pattern so that, after 16 shift edges, the pattern appears on the last serial output, most-significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both registers |
| rst | input | 1 | Synchronous active-high reset |
| diag_mode_i | input | 1 | High selects diagnostic operation |
| sec_sel_i | input | 1 | Secondary select in diagnostic mode: high shifts, low transfers in parallel |
| sdin_i | input | 1 | Serial data in; picks the direction of a parallel transfer |
| sdout_o | output | 1 | Serial data out (shadow MSB, or echo of `sdin_i`) |
| out_en_i | input | 1 | Output enable for the pins |
| pipe_d_i | input | 8 | Parallel data loaded in normal mode |
| pin_ext_i | input | 8 | Value applied externally to the pins while they are disabled |
| pipe_q_o | output | 8 | Pipeline register contents |
| pins_o | output | 8 | Value present on the output pins |

## Verification
All register results are due on the first rising edge after their controls are applied. The bench drives its inputs on a falling edge and reads the registered outputs at the next falling edge, which is half a period after the edge that updated them. `sdout_o` and `pins_o` are combinational, so they are checked in the same low phase as the stimulus, 1 ns after it is applied. The shadow register can only be seen through the serial output, so its contents are read by shifting it out one bit per edge, with each bit sampled before the edge that moves it.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int unsigned DIAG_W = 8;

    typedef enum logic [1:0] {
        OP_RUN     = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_SH2PIPE = 2'd2,
        OP_PIN2SH  = 2'd3
    } diag_op_e;

    typedef struct packed {
        logic mode;
        logic sec;
        logic sdin;
        logic oe;
    } diag_ctl_t;

    function automatic diag_op_e decode_op(diag_ctl_t c);
        if (!c.mode)     return OP_RUN;
        else if (c.sec)  return OP_SHIFT;
        else if (c.sdin) return OP_PIN2SH;
        else             return OP_SH2PIPE;
    endfunction

    function automatic logic echo_active(diag_ctl_t c);
        return c.mode && !c.sec && !c.oe;
    endfunction

endpackage

// File: rtl/diag_op_decode.sv
module diag_op_decode
    import diag_pkg::*;
(
    input  diag_ctl_t ctl,
    output diag_op_e  op,
    output logic      echo
);
    always_comb begin
        op   = decode_op(ctl);
        echo = echo_active(ctl);
    end
endmodule

// File: rtl/diag_pipe_reg.sv
module diag_pipe_reg
    import diag_pkg::*;
#(
    parameter int unsigned W = DIAG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  diag_op_e     op,
    input  logic [W-1:0] d,
    input  logic [W-1:0] shadow,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_RUN:     q <= d;
                OP_SH2PIPE: q <= shadow;
                default:    q <= q;
            endcase
        end
    end
endmodule

// File: rtl/diag_shadow_core.sv
module diag_shadow_core
    import diag_pkg::*;
#(
    parameter int unsigned W = DIAG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  diag_op_e     op,
    input  logic         sdin,
    input  logic [W-1:0] pins,
    output logic [W-1:0] q
);
    localparam int unsigned MSB = W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_SHIFT:  q <= {q[MSB-1:0], sdin};
                OP_PIN2SH: q <= pins;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/diag_shadow_reg.sv
module diag_shadow_reg
    import diag_pkg::*;
#(
    parameter int unsigned W = DIAG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         diag_mode_i,
    input  logic         sec_sel_i,
    input  logic         sdin_i,
    output logic         sdout_o,
    input  logic         out_en_i,
    input  logic [W-1:0] pipe_d_i,
    input  logic [W-1:0] pin_ext_i,
    output logic [W-1:0] pipe_q_o,
    output logic [W-1:0] pins_o
);
    localparam int unsigned MSB = W - 1;

    diag_ctl_t    ctl;
    diag_op_e     op;
    logic         echo;
    logic [W-1:0] shadow_q;
    logic [W-1:0] pipe_q;
    logic [W-1:0] pin_val;

    always_comb begin
        ctl.mode = diag_mode_i;
        ctl.sec  = sec_sel_i;
        ctl.sdin = sdin_i;
        ctl.oe   = out_en_i;
    end

    diag_op_decode u_dec (
        .ctl  (ctl),
        .op   (op),
        .echo (echo)
    );

    diag_pipe_reg #(.W(W)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .d      (pipe_d_i),
        .shadow (shadow_q),
        .q      (pipe_q)
    );

    assign pin_val = out_en_i ? pipe_q : pin_ext_i;

    diag_shadow_core #(.W(W)) u_shadow (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .sdin (sdin_i),
        .pins (pin_val),
        .q    (shadow_q)
    );

    assign pipe_q_o = pipe_q;
    assign pins_o   = pin_val;
    assign sdout_o  = echo ? sdin_i : shadow_q[MSB];

endmodule

// File: rtl/diag_shadow_checker.sv
module diag_shadow_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         mode,
    input logic         sec,
    input logic         sdin,
    input logic         oe,
    input logic         sdout,
    input logic [W-1:0] shadow_q,
    input logic [W-1:0] pipe_q,
    input logic [W-1:0] pins
);
    a_r2_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        !mode |=> shadow_q == $past(shadow_q));

    a_r3_shift_step: assert property (@(posedge clk) disable iff (rst)
        (mode && sec) |=> shadow_q == {$past(shadow_q[W-2:0]), $past(sdin)});

    a_r4_sdout_msb: assert property (@(posedge clk) disable iff (rst)
        !(mode && !sec && !oe) |-> sdout == shadow_q[W-1]);

    a_r5_to_pipe: assert property (@(posedge clk) disable iff (rst)
        (mode && !sec && !sdin) |=> pipe_q == $past(shadow_q));

    a_r6_from_pins: assert property (@(posedge clk) disable iff (rst)
        (mode && !sec && sdin) |=> shadow_q == $past(pins));

    a_r7_echo: assert property (@(posedge clk) disable iff (rst)
        (mode && !sec && !oe) |-> sdout == sdin);

    a_r8_pipe_holds: assert property (@(posedge clk) disable iff (rst)
        (mode && (sec || sdin)) |=> $stable(pipe_q));
endmodule

bind diag_shadow_reg diag_shadow_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode     (diag_mode_i),
    .sec      (sec_sel_i),
    .sdin     (sdin_i),
    .oe       (out_en_i),
    .sdout    (sdout_o),
    .shadow_q (shadow_q),
    .pipe_q   (pipe_q),
    .pins     (pins_o)
);

// File: tb/tb_diag_shadow_reg.sv
`timescale 1ns/1ps
module tb_diag_shadow_reg;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode, sec, sdin, oe;
    logic [7:0] pipe_d, pin_ext;
    logic       sdout, sdout2;
    logic [7:0] pipe_q, pins, pipe_q2, pins2;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    diag_shadow_reg dut (
        .clk(clk), .rst(rst), .diag_mode_i(mode), .sec_sel_i(sec),
        .sdin_i(sdin), .sdout_o(sdout), .out_en_i(oe),
        .pipe_d_i(pipe_d), .pin_ext_i(pin_ext),
        .pipe_q_o(pipe_q), .pins_o(pins)
    );

    diag_shadow_reg dut2 (
        .clk(clk), .rst(rst), .diag_mode_i(mode), .sec_sel_i(sec),
        .sdin_i(sdout), .sdout_o(sdout2), .out_en_i(oe),
        .pipe_d_i(pipe_d), .pin_ext_i(pin_ext),
        .pipe_q_o(pipe_q2), .pins_o(pins2)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_in(input logic [7:0] v);
        mode = 1'b1; sec = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sdin = v[i];
            step();
        end
    endtask

    task automatic read_shadow(output logic [7:0] v);
        mode = 1'b1; sec = 1'b1; sdin = 1'b0;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            #1;
            v = {v[6:0], sdout};
            step();
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pipe after reset", {8'h0, pipe_q}, 16'h0000);
        check("R1 sdout after reset", {15'h0, sdout}, 16'h0000);
        read_shadow(v);
        check("R1 shadow after reset", {8'h0, v}, 16'h0000);
    endtask

    task automatic t_shift();
        logic [7:0] v;
        logic [7:0] model;
        model = 8'h00;
        mode = 1'b1; sec = 1'b1; oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sdin = 8'hC3 >> i;
            step();
            model = {model[6:0], 1'(8'hC3 >> i)};
            check("R4 sdout shows shadow msb", {15'h0, sdout}, {15'h0, model[7]});
        end
        read_shadow(v);
        check("R3 shifted value", {8'h0, v}, 16'h00C3);
    endtask

    task automatic t_normal();
        logic [7:0] v;
        shift_in(8'h69);
        mode = 1'b0; sec = 1'b1; sdin = 1'b1; oe = 1'b1;
        pipe_d = 8'hA5; step();
        check("R2 pipe loads data", {8'h0, pipe_q}, 16'h00A5);
        pipe_d = 8'h3C; sec = 1'b0; sdin = 1'b0; step();
        check("R2 pipe loads data again", {8'h0, pipe_q}, 16'h003C);
        read_shadow(v);
        check("R2 shadow held in normal mode", {8'h0, v}, 16'h0069);
    endtask

    task automatic t_to_pipe();
        shift_in(8'h96);
        oe = 1'b1; mode = 1'b1; sec = 1'b0; sdin = 1'b0;
        #1;
        check("R4 sdout msb when enabled", {15'h0, sdout}, 16'h0001);
        step();
        check("R5 shadow copied to pipe", {8'h0, pipe_q}, 16'h0096);
        check("R6 pins show pipe when enabled", {8'h0, pins}, 16'h0096);
    endtask

    task automatic t_pins_enabled();
        logic [7:0] v;
        mode = 1'b0; pipe_d = 8'h5A; step();
        mode = 1'b1; sec = 1'b0; sdin = 1'b1; oe = 1'b1; pipe_d = 8'hFF;
        step();
        check("R8 pipe held on capture", {8'h0, pipe_q}, 16'h005A);
        read_shadow(v);
        check("R6 captured enabled pins", {8'h0, v}, 16'h005A);
        check("R8 pipe held while shifting", {8'h0, pipe_q}, 16'h005A);
    endtask

    task automatic t_pins_disabled();
        logic [7:0] v;
        mode = 1'b1; sec = 1'b0; oe = 1'b0; pin_ext = 8'hE1; sdin = 1'b1;
        #1;
        check("R6 pins show external when disabled", {8'h0, pins}, 16'h00E1);
        check("R7 sdout echoes sdin high", {15'h0, sdout}, 16'h0001);
        check("R7 chained sdout echoes", {15'h0, sdout2}, 16'h0001);
        step();
        sdin = 1'b0; sec = 1'b1;
        #1;
        sec = 1'b0;
        #1;
        check("R7 sdout echoes sdin low", {15'h0, sdout}, 16'h0000);
        sec = 1'b1;
        oe = 1'b1;
        read_shadow(v);
        check("R6 captured external pins", {8'h0, v}, 16'h00E1);
        check("R8 pipe held across capture", {8'h0, pipe_q}, 16'h005A);
    endtask

    task automatic t_chain();
        logic [15:0] pat, got;
        pat = 16'hB4E7;
        got = '0;
        mode = 1'b1; sec = 1'b1; oe = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            sdin = pat[i];
            step();
        end
        sdin = 1'b0;
        for (int i = 0; i < 16; i++) begin
            #1;
            got = {got[14:0], sdout2};
            step();
        end
        check("R9 chained 16-bit pattern", got, pat);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; mode = 1'b0; sec = 1'b0; sdin = 1'b0; oe = 1'b1;
        pipe_d = 8'h00; pin_ext = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shift();
        t_normal();
        t_to_pipe();
        t_pins_enabled();
        t_pins_disabled();
        t_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule